// File: doc/BRIEF.md
# Printer Port Host Register Block

This block sits on a simple host bus and presents three byte-wide registers for a printer port: an output/input data byte, a status byte and a control byte. Writes go through an independent write channel (address, enable, data). Reads go through an independent read channel (address, enable), and the result comes back in a registered read-data output. No printer is attached. The block models the printer handshake itself. A rising STROBE written into the control register hands the latched data byte to a sink as a one-cycle byte-valid pulse. Successive status reads walk the BUSY and ACK bits through a fixed acknowledge cycle.

The BUSY/ACK pair is held by a small state machine with four named states:
- `HS_BUSY_ACK`: busy, acknowledged.
- `HS_READY_ACK`: ready, acknowledge still showing.
- `HS_READY_IDLE`: ready, no acknowledge.
- `HS_BUSY_IDLE`: busy without acknowledge. This is the encoding's fourth value and cannot be reached.

The transitions are:
- *force*: a control write with INIT low, from any state to `HS_BUSY_ACK`.
- *release*: a strobe-high control write, which clears busy. It takes `HS_BUSY_ACK` to `HS_READY_ACK` and `HS_BUSY_IDLE` to `HS_READY_IDLE`.
- *poll-drop*: a status read while ready with stored STROBE low, from `HS_READY_ACK` to `HS_READY_IDLE`.
- *poll-rearm*: the same read condition, from `HS_READY_IDLE` to `HS_BUSY_ACK`.

When two transitions apply in the same cycle, force has priority over release, and release has priority over a poll.

A level interrupt goes high when a strobe cycle ends (STROBE written low) while the interrupt enable was already set. A status read drops it. When the DIR control bit is set, a data read returns an external input byte instead of the written byte.

Top module: `pport_host_regs`

## Requirements
- R1: After reset: control reads 0xCC, status reads 0xD9, data reads 0xFF, `irq` is 0 and `out_valid` is 0.
- R2: Register offsets are 0 for data, 1 for status and 2 for control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 and 3 to 7 changes no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. The control bits are DIR bit 5, INTEN bit 4, SELECT bit 3, INIT bit 2 and STROBE bit 0. Bit 1 is stored only.
- R4: A control write with INIT low sets BUSY (bit 7), ACK (bit 6), ONLINE (bit 4) and ERROR (bit 3), and clears PAPER (bit 5) and TIMEOUT (bit 0). Status then reads 0xD8.
- R5: A control write with INIT and SELECT high and STROBE high clears BUSY. If the stored STROBE was low, `out_valid` pulses for exactly one cycle, in the cycle after the write, with `out_byte` holding the data byte. A repeated strobe-high write emits nothing.
- R6: A control write with INIT and SELECT high and STROBE low raises `irq` in the next cycle if the previously stored control had INTEN set.
- R7: A status read returns the status and clears `irq`. If BUSY was low and the stored STROBE is low, the read then clears ACK when ACK was set; otherwise it sets both ACK and BUSY. BUSY never shows without ACK.
- R8: A data read returns `in_byte` when control DIR is set, and the last written data byte otherwise.
- R9: In one cycle with both a status read and a control write, the read returns the pre-cycle status. An interrupt raise from the write beats the read's clear. A write's force or release beats the read's handshake step.
- R10: `rd_data` updates only on the clock edge that samples `rd_en`, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_addr | input | 3 | Write register offset |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register offset |
| rd_en | input | 1 | Read enable |
| rd_data | output | 8 | Registered read data |
| in_byte | input | 8 | Byte returned by reverse-direction data reads |
| out_byte | output | 8 | Latched data byte toward the sink |
| out_valid | output | 1 | One-cycle pulse: `out_byte` is handed over |
| irq | output | 1 | Level interrupt |

## Verification
The two channels make it possible for a status read and a control write to land on the same clock edge. There, the interrupt raise meets the interrupt clear, and the write's force or release meets the read's handshake step. The bench drives both enables in one cycle from a known handshake state:
- the ready state with ACK showing and STROBE held high, with an interrupt-raising write;
- the ready state with ACK clear, with a strobe-high write.

It then judges the returned byte against the pre-cycle status, `irq` and `out_valid` in the next cycle, and the status seen by a later read, which must show the write's outcome and no handshake step.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_SEL_W = 3;

    localparam logic [REG_SEL_W-1:0] OFS_DATA = 3'd0;
    localparam logic [REG_SEL_W-1:0] OFS_STAT = 3'd1;
    localparam logic [REG_SEL_W-1:0] OFS_CTRL = 3'd2;

    // status bit positions
    localparam int ST_BUSY   = 7;
    localparam int ST_ACK    = 6;
    localparam int ST_PAPER  = 5;
    localparam int ST_ONLINE = 4;
    localparam int ST_ERROR  = 3;
    localparam int ST_TMO    = 0;

    // control bit positions
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
    localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
    localparam logic [BYTE_W-1:0] BYTE_IDLE  = 8'hFF;

    typedef enum logic [1:0] {
        HS_BUSY_ACK   = 2'd0,
        HS_READY_ACK  = 2'd1,
        HS_READY_IDLE = 2'd2,
        HS_BUSY_IDLE  = 2'd3
    } hs_state_e;
endpackage

// File: rtl/pport_handshake.sv
module pport_handshake
    import pport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic release_i,
    input  logic poll_i,
    input  logic strobe_held_i,
    output logic busy_o,
    output logic ack_o
);
    hs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (force_i) begin
            state_d = HS_BUSY_ACK;
        end else if (release_i) begin
            unique case (state_q)
                HS_BUSY_ACK:   state_d = HS_READY_ACK;
                HS_BUSY_IDLE:  state_d = HS_READY_IDLE;
                HS_READY_ACK:  state_d = HS_READY_ACK;
                HS_READY_IDLE: state_d = HS_READY_IDLE;
            endcase
        end else if (poll_i && !strobe_held_i) begin
            unique case (state_q)
                HS_READY_ACK:  state_d = HS_READY_IDLE;
                HS_READY_IDLE: state_d = HS_BUSY_ACK;
                HS_BUSY_ACK:   state_d = HS_BUSY_ACK;
                HS_BUSY_IDLE:  state_d = HS_BUSY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_BUSY_ACK;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            HS_BUSY_ACK:   begin busy_o = 1'b1; ack_o = 1'b1; end
            HS_READY_ACK:  begin busy_o = 1'b0; ack_o = 1'b1; end
            HS_READY_IDLE: begin busy_o = 1'b0; ack_o = 1'b0; end
            HS_BUSY_IDLE:  begin busy_o = 1'b1; ack_o = 1'b0; end
        endcase
    end

    p_no_lone_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && !ack_o));
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (busy_o && ack_o));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !force_i) |=> !busy_o);
    p_poll_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !strobe_held_i && !force_i && !release_i && !busy_o && ack_o)
        |=> (!busy_o && !ack_o));
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && release_i && !force_i && !busy_o && !ack_o) |=> (!busy_o && !ack_o));
endmodule

// File: rtl/pport_ctrl_unit.sv
module pport_ctrl_unit
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              poll_i,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              irq_o,
    output logic              emit_o,
    output logic              force_o,
    output logic              release_o
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] wr_val;
    logic              pend_q, emit_q;
    logic              armed, raise, fire;

    always_comb begin
        wr_val    = wdata_i | CTRL_FORCE;
        armed     = wr_val[CT_INIT] && wr_val[CT_SEL];
        force_o   = wr_i && !wr_val[CT_INIT];
        release_o = wr_i && armed && wr_val[CT_STB];
        raise     = wr_i && armed && !wr_val[CT_STB] && ctrl_q[CT_IEN];
        fire      = release_o && !ctrl_q[CT_STB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            pend_q <= 1'b0;
            emit_q <= 1'b0;
        end else begin
            if (wr_i) ctrl_q <= wr_val;
            if (raise)       pend_q <= 1'b1;
            else if (poll_i) pend_q <= 1'b0;
            emit_q <= fire;
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = pend_q;
    assign emit_o = emit_q;

    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |=> !emit_o);
    p_emit_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |-> (ctrl_o[CT_STB] && !$past(ctrl_o[CT_STB])));
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(poll_i));
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(wr_i) && !ctrl_o[CT_STB] && $past(ctrl_o[CT_IEN])));
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
    import pport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_SEL_W-1:0] wr_addr,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [REG_SEL_W-1:0] rd_addr,
    input  logic                 rd_en,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic [BYTE_W-1:0]    out_byte,
    output logic                 out_valid,
    output logic                 irq
);
    logic [BYTE_W-1:0] data_q, rd_q, rd_val, status_w, ctrl_w;
    logic wr_data_sel, wr_ctrl_sel, poll;
    logic force_w, release_w, busy_w, ack_w;
    logic paper_q, online_q, error_q, tmo_q;

    assign wr_data_sel = wr_en && (wr_addr == OFS_DATA);
    assign wr_ctrl_sel = wr_en && (wr_addr == OFS_CTRL);
    assign poll        = rd_en && (rd_addr == OFS_STAT);

    pport_ctrl_unit u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ctrl_sel),
        .wdata_i   (wr_data),
        .poll_i    (poll),
        .ctrl_o    (ctrl_w),
        .irq_o     (irq),
        .emit_o    (out_valid),
        .force_o   (force_w),
        .release_o (release_w)
    );

    pport_handshake u_hs (
        .clk           (clk),
        .rst_n         (rst_n),
        .force_i       (force_w),
        .release_i     (release_w),
        .poll_i        (poll),
        .strobe_held_i (ctrl_w[CT_STB]),
        .busy_o        (busy_w),
        .ack_o         (ack_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= BYTE_IDLE;
            paper_q  <= 1'b0;
            online_q <= 1'b1;
            error_q  <= 1'b1;
            tmo_q    <= 1'b1;
        end else begin
            if (wr_data_sel) data_q <= wr_data;
            if (force_w) begin
                paper_q  <= 1'b0;
                online_q <= 1'b1;
                error_q  <= 1'b1;
                tmo_q    <= 1'b0;
            end
        end
    end

    always_comb begin
        status_w            = '0;
        status_w[ST_BUSY]   = busy_w;
        status_w[ST_ACK]    = ack_w;
        status_w[ST_PAPER]  = paper_q;
        status_w[ST_ONLINE] = online_q;
        status_w[ST_ERROR]  = error_q;
        status_w[ST_TMO]    = tmo_q;
    end

    always_comb begin
        rd_val = BYTE_IDLE;
        case (rd_addr)
            OFS_DATA: rd_val = ctrl_w[CT_DIR] ? in_byte : data_q;
            OFS_STAT: rd_val = status_w;
            OFS_CTRL: rd_val = ctrl_w;
            default:  rd_val = BYTE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= BYTE_IDLE;
        else if (rd_en) rd_q <= rd_val;
    end

    assign rd_data  = rd_q;
    assign out_byte = data_q;

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > OFS_CTRL) |=> (rd_data == BYTE_IDLE));
    p_ignored_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != OFS_DATA) |=> $stable(out_byte));
    p_force_tmo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_w |=> (!tmo_q && online_q && error_q));
endmodule

// File: tb/test_pport_host_regs.sv
module test_pport_host_regs;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 27;
    // {rd(1), addr(8), wdata(8), expected rd or out_byte(8), irq(1), valid(1), req(4)}
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b1, 8'h02, 8'h00, 8'hCC, 1'b0, 1'b0, 4'd1},  // R1
        {1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd1},
        {1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},
        {1'b1, 8'h03, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd2},  // R2
        {1'b1, 8'h07, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd2},
        {1'b0, 8'h00, 8'h3C, 8'h00, 1'b0, 1'b0, 4'd8},  // R8
        {1'b1, 8'h00, 8'h00, 8'h3C, 1'b0, 1'b0, 4'd8},
        {1'b0, 8'h02, 8'h2C, 8'h00, 1'b0, 1'b0, 4'd3},  // R3
        {1'b1, 8'h02, 8'h00, 8'hEC, 1'b0, 1'b0, 4'd3},
        {1'b1, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b0, 4'd8},
        {1'b0, 8'h02, 8'h1C, 8'h00, 1'b0, 1'b0, 4'd6},  // R6
        {1'b1, 8'h00, 8'h00, 8'h3C, 1'b0, 1'b0, 4'd8},
        {1'b0, 8'h02, 8'h1D, 8'h3C, 1'b0, 1'b1, 4'd5},  // R5
        {1'b0, 8'h02, 8'h1D, 8'h00, 1'b0, 1'b0, 4'd5},
        {1'b0, 8'h02, 8'h1C, 8'h00, 1'b1, 1'b0, 4'd6},
        {1'b1, 8'h01, 8'h00, 8'h59, 1'b0, 1'b0, 4'd7},  // R7
        {1'b1, 8'h01, 8'h00, 8'h19, 1'b0, 1'b0, 4'd7},
        {1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd7},
        {1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd7},
        {1'b0, 8'h02, 8'h18, 8'h00, 1'b0, 1'b0, 4'd4},  // R4
        {1'b1, 8'h01, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd4},
        {1'b0, 8'h02, 8'h0C, 8'h00, 1'b1, 1'b0, 4'd6},
        {1'b1, 8'h02, 8'h00, 8'hCC, 1'b1, 1'b0, 4'd3},
        {1'b0, 8'h05, 8'h00, 8'h00, 1'b1, 1'b0, 4'd2},
        {1'b1, 8'h02, 8'h00, 8'hCC, 1'b1, 1'b0, 4'd2},
        {1'b1, 8'h00, 8'h00, 8'h3C, 1'b1, 1'b0, 4'd2},
        {1'b1, 8'h01, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, in_byte = 8'h5A;
    logic [7:0] rd_data, out_byte;
    logic       out_valid, irq;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_host_regs i_pport_host_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
        .in_byte(in_byte), .out_byte(out_byte), .out_valid(out_valid), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one cycle of either or both channels, then sample at the following negedge
    task automatic cycle(input logic do_wr, input logic [2:0] wa, input logic [7:0] wd,
                         input logic do_rd, input logic [2:0] ra);
        @(negedge clk);
        wr_en = do_wr; wr_addr = wa; wr_data = wd;
        rd_en = do_rd; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "irq after reset", {7'd0, irq}, 8'h00);
        check("R1", "out_valid after reset", {7'd0, out_valid}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [30:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[3:0]);
            cycle(!v[30], v[24:22], v[21:14], v[30], v[24:22]);
            if (v[30]) check(tag, $sformatf("rd_data vec %0d", i), rd_data, v[13:6]);
            check(tag, $sformatf("irq vec %0d", i), {7'd0, irq}, {7'd0, v[5]});
            check(tag, $sformatf("out_valid vec %0d", i), {7'd0, out_valid}, {7'd0, v[4]});
            if (v[4]) check(tag, $sformatf("out_byte vec %0d", i), out_byte, v[13:6]);
        end

        // R9: strobe-high write emits, status 0x58, stored STROBE high
        cycle(1'b1, 3'd2, 8'h1D, 1'b0, 3'd0);
        check("R5", "emit before collision", {7'd0, out_valid}, 8'h01);
        // R9: raise (prev INTEN set, STROBE low) against status-read clear
        cycle(1'b1, 3'd2, 8'h1C, 1'b1, 3'd1);
        check("R9", "read returns pre-cycle status", rd_data, 8'h58);
        check("R9", "raise beats clear", {7'd0, irq}, 8'h01);
        cycle(1'b0, 3'd0, 8'h00, 1'b1, 3'd1);
        check("R7", "status then ack drop", rd_data, 8'h58);
        check("R7", "irq cleared by read", {7'd0, irq}, 8'h00);
        // R9: ready/idle; strobe-high write against a rearming poll
        cycle(1'b1, 3'd2, 8'h1D, 1'b1, 3'd1);
        check("R9", "pre-cycle status", rd_data, 8'h18);
        check("R9", "emit in collision", {7'd0, out_valid}, 8'h01);
        cycle(1'b0, 3'd0, 8'h00, 1'b1, 3'd1);
        check("R9", "write beats poll step", rd_data, 8'h18);
        check("R5", "no repeat emit", {7'd0, out_valid}, 8'h00);

        // R10: rd_data holds with no read while registers change
        cycle(1'b1, 3'd2, 8'h0C, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        check("R10", "rd_data held", rd_data, 8'h18);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", "irq after re-reset", {7'd0, irq}, 8'h00);
        check("R1", "rd_data after re-reset", rd_data, 8'hFF);
        cycle(1'b0, 3'd0, 8'h00, 1'b1, 3'd2);
        check("R1", "control after re-reset", rd_data, 8'hCC);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule